// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives an external clock output from the bus clock. A small divider code and a separate disable bit pick one of three behaviours: an even division of the bus clock with a 50 percent duty cycle, a straight pass-through of the bus clock, or a quiet output held low. A configuration register outside this block holds the two fields and drives them straight in.

A three-state machine runs the output. The states are `ST_DIVIDE` (registered square wave), `ST_FOLLOW` (the bus clock gated through) and `ST_MUTE` (output low). One transition, named the boundary reload, leaves every state. It fires at the end of the low half of a divided period, and on every clock edge in `ST_FOLLOW` and `ST_MUTE`. At that point the machine reads the inputs and picks its next state. The disable bit selects `ST_MUTE`. Otherwise the all-ones code selects `ST_FOLLOW`, and any other code selects `ST_DIVIDE`. Entering `ST_DIVIDE` always starts with the high half of a fresh period. All other edges in `ST_DIVIDE` either hold the level or toggle it at the end of a half period.

The pass-through gate is updated on the falling clock edge, while the clock is low. Moving into or out of `ST_FOLLOW` therefore never slices a pulse.

Top module: `clkout_divider`

## Requirements
- R1: For a divider code c from 0 to 6 with the disable bit at 0, the output is high for c+1 bus clock cycles and then low for c+1 cycles. This gives a ratio of 2*(c+1) at 50 percent duty.
- R2: For divider code 7 (all ones) with the disable bit at 0, the output follows the bus clock. It is high while the bus clock is high and low while the bus clock is low.
- R3: With the disable bit at 1, the output stays low for every divider code.
- R4: A new code or disable value is applied only at the end of the low half of the current divided period. A period already in progress completes at its old ratio.
- R5: While reset is asserted the output is low. The first clock edge after release acts as a boundary and starts a high half, using the code presented at that edge.
- R6: When leaving the disabled or pass-through behaviour for a divided ratio, the output rises at the very next clock edge. The first high half lasts the full c+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock, the source of the output |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | CODE_W | Divider code; all ones means pass-through |
| out_off_i | input | 1 | 1 holds the output low |
| clk_o | output | 1 | Divided, passed-through or quiet clock output |

## Verification
The bench builds the block with the default CODE_W of 3. With that width the vector table can visit all eight codes: every even ratio from 2 to 14, the pass-through code, and the disable bit paired with both a dividing and the pass-through code. Because the widest half period is seven cycles, the bench can change the code in the middle of a high half and still watch the whole old period finish before the new ratio appears. It can also watch the reset release and both entries into division within a few dozen cycles.

// File: rtl/cko_pkg.sv
`timescale 1ns/100ps
package cko_pkg;

    typedef enum logic [1:0] {
        ST_MUTE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_FOLLOW = 2'd2
    } ck_state_e;

    // Target behaviour chosen at a boundary reload.
    function automatic ck_state_e pick_state(input logic off, input logic follow);
        if (off) begin
            return ST_MUTE;
        end else if (follow) begin
            return ST_FOLLOW;
        end
        return ST_DIVIDE;
    endfunction

endpackage

// File: rtl/cko_half_counter.sv
`timescale 1ns/100ps
module cko_half_counter #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic [W-1:0] half_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    localparam logic [W-1:0] STEP = W'(1);

    logic [W-1:0] cnt_q;

    // Last cycle of the current half period.
    assign last_o = (cnt_q == (half_i - STEP));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + STEP;
        end
    end

endmodule

// File: rtl/cko_seq.sv
`timescale 1ns/100ps
module cko_seq
    import cko_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              off_i,
    input  logic              last_i,
    input  logic [CODE_W-1:0] cnt_i,
    output ck_state_e         state_o,
    output logic              level_o,
    output logic [CODE_W-1:0] half_o,
    output logic              clear_o,
    output logic              boundary_o
);

    localparam logic [CODE_W-1:0] FOLLOW_CODE = '1;
    localparam logic [CODE_W-1:0] ONE         = CODE_W'(1);

    ck_state_e         state_q, state_d, target;
    logic              level_q, level_d;
    logic [CODE_W-1:0] half_q, half_d;
    logic              boundary;

    assign target   = pick_state(off_i, code_i == FOLLOW_CODE);
    assign boundary = (state_q != ST_DIVIDE) || (last_i && !level_q);

    // Next-state decode: every transition is the boundary reload.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MUTE:   state_d = target;
            ST_FOLLOW: state_d = target;
            ST_DIVIDE: if (boundary) state_d = target;
            default:   state_d = ST_MUTE;
        endcase
    end

    // Output level and latched half length.
    always_comb begin
        level_d = level_q;
        half_d  = half_q;
        if (boundary) begin
            level_d = (target == ST_DIVIDE);
            if (target == ST_DIVIDE) begin
                half_d = code_i + ONE;
            end
        end else if (last_i) begin
            level_d = ~level_q;
        end
    end

    // Reset state stands at a boundary with the divide-by-two setting.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_DIVIDE;
            level_q <= 1'b0;
            half_q  <= ONE;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            half_q  <= half_d;
        end
    end

    assign state_o    = state_q;
    assign level_o    = level_q;
    assign half_o     = half_q;
    assign clear_o    = (state_q != ST_DIVIDE);
    assign boundary_o = boundary;

    // R1: half-period counter stays inside the latched half length
    a_r1_cnt_in_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DIVIDE) |-> (cnt_i < half_q));

    // R1: level holds until the counter reaches the end of a half
    a_r1_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DIVIDE && !last_i) |=> $stable(level_q));

    // R4: ratio only reloads at a boundary
    a_r4_ratio_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boundary |=> $stable(half_q));

    // R4: divide state is kept between boundaries
    a_r4_state_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DIVIDE && !boundary) |=> (state_q == ST_DIVIDE));

endmodule

// File: rtl/cko_out_gate.sv
`timescale 1ns/100ps
module cko_out_gate
    import cko_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  ck_state_e state_i,
    input  logic      level_i,
    output logic      clk_o
);

    logic follow_q;

    // Updated while the clock is low so the gate never cuts a pulse.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            follow_q <= 1'b0;
        end else begin
            follow_q <= (state_i == ST_FOLLOW);
        end
    end

    assign clk_o = level_i | (follow_q & clk_i);

    // R3: quiet state drives neither the level nor the gate
    a_r3_mute_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_MUTE) |-> (!follow_q && !level_i));

    // R2: pass-through opens the gate and parks the level low
    a_r2_follow_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_FOLLOW) |-> (follow_q && !level_i));

endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/100ps
module clkout_divider
    import cko_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic              out_off_i,
    output logic              clk_o
);

    ck_state_e         state;
    logic              level;
    logic [CODE_W-1:0] half_len;
    logic [CODE_W-1:0] cnt;
    logic              last;
    logic              clear;
    logic              boundary;

    cko_half_counter #(.W(CODE_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .half_i  (half_len),
        .cnt_o   (cnt),
        .last_o  (last)
    );

    cko_seq #(.CODE_W(CODE_W)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .code_i     (div_code_i),
        .off_i      (out_off_i),
        .last_i     (last),
        .cnt_i      (cnt),
        .state_o    (state),
        .level_o    (level),
        .half_o     (half_len),
        .clear_o    (clear),
        .boundary_o (boundary)
    );

    cko_out_gate u_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_i (state),
        .level_i (level),
        .clk_o   (clk_o)
    );

    // R6: leaving mute or follow for a divided code raises the level next edge
    a_r6_entry_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state != ST_DIVIDE && boundary && !out_off_i && div_code_i != '1)
        |=> (level && state == ST_DIVIDE));

endmodule

// File: tb/sim_clkout_divider.sv
`timescale 1ns/100ps
module sim_clkout_divider;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] code  = 3'd5;
    logic       off   = 1'b0;
    logic       clk_o;

    always #2.5 clk = ~clk;

    clkout_divider #(.CODE_W(3)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .div_code_i (code),
        .out_off_i  (off),
        .clk_o      (clk_o)
    );

    localparam logic [1:0] K_DIV = 2'd0, K_FOL = 2'd1, K_OFF = 2'd2;

    typedef struct packed {
        logic [2:0] code;
        logic       off;
        logic [1:0] kind;
        logic [3:0] half;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{3'd3, 1'b0, K_DIV, 4'd4},
        '{3'd0, 1'b0, K_DIV, 4'd1},
        '{3'd6, 1'b0, K_DIV, 4'd7},
        '{3'd7, 1'b0, K_FOL, 4'd0},
        '{3'd1, 1'b0, K_DIV, 4'd2},
        '{3'd3, 1'b1, K_OFF, 4'd0},
        '{3'd5, 1'b0, K_DIV, 4'd6},
        '{3'd2, 1'b0, K_DIV, 4'd3},
        '{3'd7, 1'b1, K_OFF, 4'd0},
        '{3'd4, 1'b0, K_DIV, 4'd5}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit hs, ls;
    bit lo_s [64];
    bit hi_s [64];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One bus cycle: sample in the high phase, then in the low phase.
    task automatic cyc();
        @(posedge clk);
        #1.0 hs = clk_o;
        #2.5 ls = clk_o;
    endtask

    task automatic grab(input int n);
        for (int i = 0; i < n; i++) begin
            cyc();
            lo_s[i] = ls;
            hi_s[i] = hs;
        end
    endtask

    function automatic int run_len(input int start, input bit val, input int n);
        int k = 0;
        for (int i = start; i < n; i++) begin
            if (lo_s[i] != val) break;
            k++;
        end
        return k;
    endfunction

    task automatic runs(input int n, output int hi, output int lo);
        int i = 1;
        while (i < n && !(lo_s[i-1] == 1'b0 && lo_s[i] == 1'b1)) i++;
        hi = run_len(i, 1'b1, n);
        lo = run_len(i + hi, 1'b0, n);
    endtask

    task automatic wait_rise();
        bit prev;
        cyc();
        prev = ls;
        for (int i = 0; i < 40; i++) begin
            cyc();
            if (!prev && ls) break;
            prev = ls;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #1000000.0;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int hi, lo, ones_h, ones_l, mism;
        // R5: output low during reset, both phases
        ones_h = 0;
        for (int i = 0; i < 3; i++) begin
            cyc();
            ones_h += int'(hs) + int'(ls);
        end
        chk("R5", "output during reset", ones_h, 0);
        rst_n = 1'b1;
        grab(20);
        chk("R5", "rise at first edge", int'(lo_s[0]), 1);
        chk("R5", "first high half code 5", run_len(0, 1'b1, 20), 6);
        chk("R1", "first low half code 5", run_len(6, 1'b0, 20), 6);

        // Table walk over codes and disable settings
        for (int v = 0; v < NV; v++) begin
            code = VT[v].code;
            off  = VT[v].off;
            repeat (40) cyc();
            grab(48);
            ones_h = 0;
            ones_l = 0;
            for (int i = 0; i < 48; i++) begin
                ones_h += int'(hi_s[i]);
                ones_l += int'(lo_s[i]);
            end
            case (VT[v].kind)
                K_DIV: begin
                    runs(48, hi, lo);
                    chk("R1", $sformatf("high half code %0d", VT[v].code), hi, int'(VT[v].half));
                    chk("R1", $sformatf("low half code %0d", VT[v].code), lo, int'(VT[v].half));
                end
                K_FOL: begin
                    chk("R2", "high-phase samples", ones_h, 48);
                    chk("R2", "low-phase samples", ones_l, 0);
                end
                default: begin
                    chk("R3", $sformatf("samples with off, code %0d", VT[v].code), ones_h + ones_l, 0);
                end
            endcase
        end

        // R4: code change in the middle of a high half
        off  = 1'b0;
        code = 3'd6;
        repeat (30) cyc();
        wait_rise();
        lo_s[0] = ls;
        for (int i = 1; i < 3; i++) begin cyc(); lo_s[i] = ls; end
        code = 3'd0;
        for (int i = 3; i < 18; i++) begin cyc(); lo_s[i] = ls; end
        mism = 0;
        for (int i = 0; i < 18; i++) begin
            bit e;
            e = (i < 7) ? 1'b1 : (i < 14) ? 1'b0 : ((i - 14) % 2 == 0);
            if (lo_s[i] != e) mism++;
        end
        chk("R4", "old period completes before ratio 2", mism, 0);

        // R4: disable in the middle of a high half
        code = 3'd6;
        repeat (30) cyc();
        wait_rise();
        lo_s[0] = ls;
        for (int i = 1; i < 3; i++) begin cyc(); lo_s[i] = ls; end
        off = 1'b1;
        for (int i = 3; i < 24; i++) begin cyc(); lo_s[i] = ls; end
        chk("R4", "high half finishes before mute", run_len(0, 1'b1, 24), 7);
        chk("R4", "low after mute", run_len(7, 1'b0, 24), 17);

        // R6: entry from mute
        off  = 1'b0;
        code = 3'd2;
        grab(12);
        chk("R6", "rise after mute", int'(lo_s[0]), 1);
        chk("R6", "first high half from mute", run_len(0, 1'b1, 12), 3);
        chk("R6", "first low half from mute", run_len(3, 1'b0, 12), 3);

        // R6: entry from follow
        code = 3'd7;
        repeat (10) cyc();
        code = 3'd1;
        grab(8);
        chk("R6", "first high half from follow", run_len(0, 1'b1, 8), 2);
        chk("R6", "first low half from follow", run_len(2, 1'b0, 8), 2);

        done = 1;
        summary();
        $finish;
    end

endmodule